// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block owns the microprogram counter of a microcoded controller. Each clock cycle it takes fields of the microword currently read from an external control store and computes the address of the next microword. The inputs are a 9-bit next-address field, a 2-bit branch mode, a 2-bit flag selector, the four ALU flags and the 8-bit instruction register. The counter value is driven straight out as the control-store read address.

Four branch modes are supported. Mode 0 is a plain jump. Mode 1 is a two-way branch that puts one selected flag into the address LSB. Modes 2 and 3 are 16-way dispatches that put the upper or the lower half of the instruction register into the low four address bits. One reserved microword acts as a stop marker. When the sequencer sees it, the counter freezes and a sticky halted output stays high until the next reset.

Top module: `microseq`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, sets the counter to 0 and clears `halted`. Reset takes priority over every other input, including the stop marker.
- R2: With `br_mode` = 0 and no stop marker present, the counter loads `addr_field` unchanged on the next rising edge.
- R3: With `br_mode` = 1, the counter loads `{addr_field[8:1], f}`. The bit f is chosen by `test_sel`: 0 selects N = `flags[3]`, 1 selects Z = `flags[2]`, 2 selects V = `flags[1]` and 3 selects C = `flags[0]`.
- R4: With `br_mode` = 2, the counter loads `{addr_field[8:4], ir[7:4]}`.
- R5: With `br_mode` = 3 and no stop marker present, the counter loads `{addr_field[8:4], ir[3:0]}`.
- R6: The stop marker is `addr_field` = 511 with `br_mode` = 3 and `test_sel` = 3. When the marker is present and the block is not halted, the counter keeps its value and `halted` is 1 after the next rising edge.
- R7: While `halted` is 1 and reset is low, the counter and `halted` do not change, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_field | input | 9 | Next-address field of the current microword |
| br_mode | input | 2 | Branch mode: 0 jump, 1 flag branch, 2 high-nibble dispatch, 3 low-nibble dispatch |
| test_sel | input | 2 | Flag selector for mode 1 |
| flags | input | 4 | ALU flags {N, Z, V, C} |
| ir | input | 8 | Instruction register |
| upc | output | 9 | Current microprogram address |
| halted | output | 1 | Sticky stop indication |

## Verification
The stop marker is itself a valid low-nibble dispatch encoding, so in one cycle the halt detection and the mode 3 dispatch both claim the counter. The bench provokes this collision by presenting the marker while `ir[3:0]` is non-zero, which gives a dispatch target different from the current address. It passes only if the counter keeps its old value and `halted` rises. A second collision, reset together with the marker, is judged by requiring the counter to be 0 and `halted` to be low after that edge.

// File: rtl/microseq.sv
module microseq #(
  parameter int AW = 9,
  parameter int IRW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_field,
  input  logic [1:0]    br_mode,
  input  logic [1:0]    test_sel,
  input  logic [3:0]    flags,
  input  logic [IRW-1:0] ir,
  output logic [AW-1:0] upc,
  output logic          halted
);
  localparam int NW = IRW / 2;

  logic          flag_bit;
  logic          stop_word;
  logic [AW-1:0] nxt;

  assign flag_bit  = flags[3 - test_sel];
  assign stop_word = (&addr_field) && (&br_mode) && (&test_sel);

  always_comb begin
    case (br_mode)
      2'd0:    nxt = addr_field;
      2'd1:    nxt = {addr_field[AW-1:1], flag_bit};
      2'd2:    nxt = {addr_field[AW-1:NW], ir[IRW-1:NW]};
      default: nxt = {addr_field[AW-1:NW], ir[NW-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc    <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (stop_word) halted <= 1'b1;
      else           upc    <= nxt;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> (upc == '0 && !halted));
  assert_jump_R2: assert property (@(posedge clk) disable iff (rst)
    (!halted && br_mode == 2'd0) |=> upc == $past(addr_field));
  assert_hinib_R4: assert property (@(posedge clk) disable iff (rst)
    (!halted && br_mode == 2'd2) |=> upc[NW-1:0] == $past(ir[IRW-1:NW]));
  assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (!halted && stop_word) |=> (halted && $stable(upc)));
  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(upc)));
endmodule

// File: tb/tb_microseq.sv
module tb_microseq;
  logic       clk = 1'b0;
  logic       rst;
  logic [8:0] addr_field;
  logic [1:0] br_mode, test_sel;
  logic [3:0] flags;
  logic [7:0] ir;
  logic [8:0] upc;
  logic       halted;
  int checks = 0, errors = 0;
  bit done = 0;

  microseq dut (.clk(clk), .rst(rst), .addr_field(addr_field), .br_mode(br_mode),
    .test_sel(test_sel), .flags(flags), .ir(ir), .upc(upc), .halted(halted));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit r, input [8:0] f, input [1:0] m, input [1:0] s,
                      input [3:0] fl, input [7:0] i);
    @(negedge clk);
    rst = r; addr_field = f; br_mode = m; test_sel = s; flags = fl; ir = i;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    step(1, 9'h155, 0, 0, 0, 0);
    check(upc == 0, "R1 upc", upc, 0);
    check(!halted, "R1 halted", halted, 0);
  endtask

  task automatic t_jump();
    step(0, 9'd300, 0, 3, 4'hF, 8'hFF);
    check(upc == 300, "R2", upc, 300);
    step(0, 9'd511, 0, 3, 0, 0);
    check(upc == 511 && !halted, "R2 top", upc, 511);
  endtask

  task automatic t_flag();
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 2; v++) begin
        logic [3:0] fl = v ? (4'b1000 >> s) : ~(4'b1000 >> s);
        step(0, 9'd100, 1, s[1:0], fl, 0);
        check(upc == (9'd100 | v), "R3", upc, 100 | v);
      end
    end
    step(0, 9'd101, 1, 1, 4'b0000, 0);
    check(upc == 100, "R3 lsb cleared", upc, 100);
  endtask

  task automatic t_hinib();
    step(0, 9'h1A5, 2, 0, 0, 8'h3C);
    check(upc == 9'h1A3, "R4", upc, 9'h1A3);
    step(0, 9'h00F, 2, 0, 0, 8'h0F);
    check(upc == 9'h000, "R4 zero", upc, 0);
  endtask

  task automatic t_lonib();
    step(0, 9'h1A5, 3, 0, 0, 8'h3C);
    check(upc == 9'h1AC, "R5", upc, 9'h1AC);
    step(0, 9'h1FF, 3, 2, 0, 8'h07);
    check(upc == 9'h1F7 && !halted, "R5 near marker", upc, 9'h1F7);
  endtask

  task automatic t_halt_collide();
    step(0, 9'd40, 0, 0, 0, 0);
    step(0, 9'd511, 3, 3, 4'hF, 8'h05);
    check(upc == 40, "R6 upc held", upc, 40);
    check(halted, "R6 halted", halted, 1);
  endtask

  task automatic t_frozen();
    step(0, 9'd7, 0, 0, 0, 0);
    check(upc == 40 && halted, "R7 jump ignored", upc, 40);
    step(0, 9'd0, 2, 0, 0, 8'hF0);
    check(upc == 40 && halted, "R7 dispatch ignored", upc, 40);
  endtask

  task automatic t_reset_priority();
    step(1, 9'd511, 3, 3, 0, 8'h05);
    check(upc == 0 && !halted, "R1 reset over marker", upc, 0);
    step(0, 9'd9, 0, 0, 0, 0);
    check(upc == 9 && !halted, "R1 runs after reset", upc, 9);
  endtask

  initial begin
    rst = 1; addr_field = 0; br_mode = 0; test_sel = 0; flags = 0; ir = 0;
    t_reset();
    t_jump();
    t_flag();
    t_hinib();
    t_lonib();
    t_halt_collide();
    t_frozen();
    t_reset_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule